// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the device-side command interpreter of a NOR-style flash model. Each bus write (address, data and a one-cycle write strobe) is matched against the multi-cycle command sequences the device understands. When a sequence completes, the block issues a one-cycle program request that carries the target address and data, or a one-cycle chip-erase request. It then reports busy until an abstracted embedded-algorithm engine signals completion.

The decoder tracks three operating conditions. The first is normal read-array operation, where every command starts with a two-write unlock. The second is a persistent fast-program mode, where a program needs only a two-write sequence and only two commands are honoured. The third is a busy condition, during which every write is discarded. Command cycles compare only the low `CMD_ADDR_BITS` address bits and the low data byte. The program data cycle latches the full address and data buses.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `busy`, `fast_mode`, `prog_req` and `erase_req` are 0, `read_mode` is 1, and `prog_addr`/`prog_data` are 0.
- R2: The writes AAh@555h, 55h@2AAh and A0h@555h, followed by any address/data write, raise `prog_req` for exactly one cycle, starting the cycle after that write. `prog_addr`/`prog_data` carry that write's values, and `busy` rises in the same cycle.
- R3: While a program is busy, every write is ignored. A pulse on `op_done` returns the decoder to the mode it was in before the program (read-array or fast mode) on the next cycle.
- R4: The writes AAh@555h, 55h@2AAh and 20h@555h set `fast_mode` on the cycle after the third write.
- R5: In fast mode, a write of A0h (at any address) followed by any address/data write issues a program request, timed as in R2, without unlock cycles.
- R6: In fast mode, a write whose low byte is neither A0h nor 90h changes nothing. This includes unlock and erase codes.
- R7: In fast mode, a write of 90h followed by a write of 00h (any addresses) clears `fast_mode` one cycle after the 00h write. A 90h followed by any other value leaves fast mode set and discards both writes.
- R8: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and 10h@555h raise `erase_req` for one cycle after the sixth write, with `busy` rising in the same cycle.
- R9: While a chip erase is busy, every write is ignored, and `op_done` returns the decoder to read-array mode.
- R10: Outside fast mode, any command-cycle write that does not match the expected next cycle aborts the sequence. This includes F0h. A fresh full sequence is then required.
- R11: Command cycles decode only address bits [10:0]. Higher address bits do not affect command matching.
- R12: `op_done` has no effect when the decoder is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; the command code is in bits [7:0] |
| op_done | input | 1 | Embedded algorithm finished |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Address of the program request |
| prog_data | output | DATA_W | Data of the program request |
| erase_req | output | 1 | One-cycle chip-erase request |
| busy | output | 1 | Embedded operation in progress |
| fast_mode | output | 1 | Unlock-free program mode active |
| read_mode | output | 1 | Array reads valid (neither busy nor fast mode) |

## Verification
A wrong sequence position inside the decoder is mostly invisible until a sequence completes. It then shows up as a missing or spurious `prog_req`/`erase_req` on the cycle after the final write, so the bench compares every output on every clock against a queue-based model. A wrong mode state is visible at once on `fast_mode`, `busy` or `read_mode`, one cycle after the write or `op_done` that caused it. Tests that break sequences at each position, and tests that write during busy, drive the decoder into the states where such errors diverge.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_UNL1,
      ST_UNL2,
      ST_PDATA,
      ST_SETUP,
      ST_EUNL1,
      ST_EUNL2,
      ST_PBUSY,
      ST_EBUSY,
      ST_FAST,
      ST_FPDATA,
      ST_FRST,
      ST_FPBUSY
   } fcd_state_e;

   typedef struct packed {
      logic unl1;      // AAh at 555h
      logic unl2;      // 55h at 2AAh
      logic cmd_prog;  // A0h at 555h
      logic cmd_fast;  // 20h at 555h
      logic cmd_setup; // 80h at 555h
      logic cmd_erase; // 10h at 555h
      logic data_a0;   // A0h, any address
      logic data_90;   // 90h, any address
      logic data_00;   // 00h, any address
   } fcd_match_t;

   localparam logic [10:0] ADR_UNL_A = 11'h555;
   localparam logic [10:0] ADR_UNL_B = 11'h2AA;
   localparam logic [7:0]  CODE_UNL_A = 8'hAA;
   localparam logic [7:0]  CODE_UNL_B = 8'h55;
   localparam logic [7:0]  CODE_PROG  = 8'hA0;
   localparam logic [7:0]  CODE_FAST  = 8'h20;
   localparam logic [7:0]  CODE_SETUP = 8'h80;
   localparam logic [7:0]  CODE_ERASE = 8'h10;
   localparam logic [7:0]  CODE_FEXIT = 8'h90;
   localparam logic [7:0]  CODE_FZERO = 8'h00;

endpackage

// File: rtl/fcd_cycle_match.sv
module fcd_cycle_match
   import fcd_pkg::*;
#(
   parameter int CMD_ADDR_BITS = 11
) (
   input  logic [CMD_ADDR_BITS-1:0] cmd_addr,
   input  logic [7:0]               cmd_byte,
   output fcd_match_t               m
);

   localparam logic [CMD_ADDR_BITS-1:0] A_KEY = CMD_ADDR_BITS'(ADR_UNL_A);
   localparam logic [CMD_ADDR_BITS-1:0] B_KEY = CMD_ADDR_BITS'(ADR_UNL_B);

   logic at_a;
   logic at_b;

   assign at_a = (cmd_addr == A_KEY);
   assign at_b = (cmd_addr == B_KEY);

   always_comb begin
      m           = '0;
      m.unl1      = at_a && (cmd_byte == CODE_UNL_A);
      m.unl2      = at_b && (cmd_byte == CODE_UNL_B);
      m.cmd_prog  = at_a && (cmd_byte == CODE_PROG);
      m.cmd_fast  = at_a && (cmd_byte == CODE_FAST);
      m.cmd_setup = at_a && (cmd_byte == CODE_SETUP);
      m.cmd_erase = at_a && (cmd_byte == CODE_ERASE);
      m.data_a0   = (cmd_byte == CODE_PROG);
      m.data_90   = (cmd_byte == CODE_FEXIT);
      m.data_00   = (cmd_byte == CODE_FZERO);
   end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
   import fcd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  fcd_match_t m,
   input  logic       op_done,
   output fcd_state_e state_q,
   output logic       prog_fire,
   output logic       erase_fire
);

   fcd_state_e state_d;

   always_comb begin
      state_d    = state_q;
      prog_fire  = 1'b0;
      erase_fire = 1'b0;
      unique case (state_q)
         ST_IDLE:   if (wr_en && m.unl1) state_d = ST_UNL1;
         ST_UNL1:   if (wr_en) state_d = m.unl2 ? ST_UNL2 : ST_IDLE;
         ST_UNL2: begin
            if (wr_en) begin
               if (m.cmd_prog)       state_d = ST_PDATA;
               else if (m.cmd_fast)  state_d = ST_FAST;
               else if (m.cmd_setup) state_d = ST_SETUP;
               else                  state_d = ST_IDLE;
            end
         end
         ST_PDATA: begin
            if (wr_en) begin
               prog_fire = 1'b1;
               state_d   = ST_PBUSY;
            end
         end
         ST_SETUP:  if (wr_en) state_d = m.unl1 ? ST_EUNL1 : ST_IDLE;
         ST_EUNL1:  if (wr_en) state_d = m.unl2 ? ST_EUNL2 : ST_IDLE;
         ST_EUNL2: begin
            if (wr_en) begin
               if (m.cmd_erase) begin
                  erase_fire = 1'b1;
                  state_d    = ST_EBUSY;
               end else begin
                  state_d = ST_IDLE;
               end
            end
         end
         ST_PBUSY:  if (op_done) state_d = ST_IDLE;
         ST_EBUSY:  if (op_done) state_d = ST_IDLE;
         ST_FAST: begin
            if (wr_en) begin
               if (m.data_a0)      state_d = ST_FPDATA;
               else if (m.data_90) state_d = ST_FRST;
            end
         end
         ST_FPDATA: begin
            if (wr_en) begin
               prog_fire = 1'b1;
               state_d   = ST_FPBUSY;
            end
         end
         ST_FRST:   if (wr_en) state_d = m.data_00 ? ST_IDLE : ST_FAST;
         ST_FPBUSY: if (op_done) state_d = ST_FAST;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   // R6: unrecognised writes in fast mode leave the mode untouched
   assert_fast_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FAST && wr_en && !m.data_a0 && !m.data_90) |=> state_q == ST_FAST);

   // R10: a mismatching second unlock aborts to idle
   assert_abort_unl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_UNL1 || state_q == ST_EUNL1) && wr_en && !m.unl2) |=> state_q == ST_IDLE);

   // R12: completion outside a busy state does nothing
   assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && op_done && !wr_en) |=> state_q == ST_IDLE);

endmodule

// File: rtl/fcd_req_out.sv
module fcd_req_out #(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_fire,
   input  logic              erase_fire,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              prog_req,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              erase_req
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prog_req  <= 1'b0;
         erase_req <= 1'b0;
         prog_addr <= '0;
         prog_data <= '0;
      end else begin
         prog_req  <= prog_fire;
         erase_req <= erase_fire;
         if (prog_fire) begin
            prog_addr <= wr_addr;
            prog_data <= wr_data;
         end
      end
   end

   // R2: request is a single-cycle pulse
   assert_prog_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |=> !prog_req);

   // R8: erase request is a single-cycle pulse
   assert_erase_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |=> !erase_req);

   // R2: captured address and data hold between requests
   assert_prog_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_fire |=> $stable(prog_addr) && $stable(prog_data));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import fcd_pkg::*;
#(
   parameter int ADDR_W        = 20,
   parameter int DATA_W        = 16,
   parameter int CMD_ADDR_BITS = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              op_done,
   output logic              prog_req,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              erase_req,
   output logic              busy,
   output logic              fast_mode,
   output logic              read_mode
);

   localparam bit ADDR_WIDER = (ADDR_W > CMD_ADDR_BITS);

   generate
      if (CMD_ADDR_BITS < 11) begin : g_bad_cab
         $error("CMD_ADDR_BITS must be at least 11");
      end
      if (DATA_W < 8) begin : g_bad_dw
         $error("DATA_W must be at least 8");
      end
      if (ADDR_W < 1) begin : g_bad_aw
         $error("ADDR_W must be positive");
      end
   endgenerate

   logic [CMD_ADDR_BITS-1:0] cmd_addr;
   logic [7:0]               cmd_byte;
   fcd_match_t               m;
   fcd_state_e               state_q;
   logic                     prog_fire;
   logic                     erase_fire;

   generate
      if (ADDR_WIDER) begin : g_addr_slice
         assign cmd_addr = wr_addr[CMD_ADDR_BITS-1:0];
      end else begin : g_addr_ext
         assign cmd_addr = CMD_ADDR_BITS'(wr_addr);
      end
   endgenerate

   assign cmd_byte = wr_data[7:0];

   fcd_cycle_match #(.CMD_ADDR_BITS(CMD_ADDR_BITS)) i_match (
      .cmd_addr (cmd_addr),
      .cmd_byte (cmd_byte),
      .m        (m)
   );

   fcd_seq_fsm i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .m          (m),
      .op_done    (op_done),
      .state_q    (state_q),
      .prog_fire  (prog_fire),
      .erase_fire (erase_fire)
   );

   fcd_req_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .prog_fire  (prog_fire),
      .erase_fire (erase_fire),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .prog_req   (prog_req),
      .prog_addr  (prog_addr),
      .prog_data  (prog_data),
      .erase_req  (erase_req)
   );

   assign busy      = (state_q == ST_PBUSY) || (state_q == ST_EBUSY) || (state_q == ST_FPBUSY);
   assign fast_mode = (state_q == ST_FAST) || (state_q == ST_FPDATA) ||
                      (state_q == ST_FRST) || (state_q == ST_FPBUSY);
   assign read_mode = !busy && !fast_mode;

   // R2: every request coincides with busy
   assert_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> busy);

   // R8: an erase request happens only outside fast mode
   assert_erase_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> busy && !fast_mode);

   // R3 / R9: busy persists until completion, and the mode is frozen
   assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !op_done) |=> busy && $stable(fast_mode) && !prog_req && !erase_req);

   // R9: busy only begins with a request
   assert_busy_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (prog_req || erase_req));

endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

   localparam int AW = 20;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          op_done = 1'b0;
   logic          prog_req, erase_req, busy, fast_mode, read_mode;
   logic [AW-1:0] prog_addr;
   logic [DW-1:0] prog_data;

   always #4 clk = ~clk;

   flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .CMD_ADDR_BITS(11)) i_flash_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .op_done(op_done), .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
      .erase_req(erase_req), .busy(busy), .fast_mode(fast_mode), .read_mode(read_mode)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string tag = "R1";
   bit    done_flag = 0;

   // behavioural reference model
   logic [AW-1:0] qa[$];
   logic [7:0]    qd[$];
   logic [7:0]    fq[$];
   bit            e_busy, e_fast, e_preq, e_ereq;
   logic [AW-1:0] e_paddr;
   logic [DW-1:0] e_pdata;

   function automatic bit cyc(int i, logic [10:0] a, logic [7:0] d);
      return (qa[i][10:0] == a) && (qd[i] == d);
   endfunction

   // 0 mismatch, 1 prefix, 2 program, 3 fast entry, 4 erase
   function automatic int verdict();
      int n = qa.size();
      if (!cyc(0, 11'h555, 8'hAA)) return 0;
      if (n == 1) return 1;
      if (!cyc(1, 11'h2AA, 8'h55)) return 0;
      if (n == 2) return 1;
      if (qa[2][10:0] != 11'h555) return 0;
      if (qd[2] == 8'h20) return 3;
      if (qd[2] == 8'hA0) return (n == 3) ? 1 : 2;
      if (qd[2] != 8'h80) return 0;
      if (n == 3) return 1;
      if (!cyc(3, 11'h555, 8'hAA)) return 0;
      if (n == 4) return 1;
      if (!cyc(4, 11'h2AA, 8'h55)) return 0;
      if (n == 5) return 1;
      if (!cyc(5, 11'h555, 8'h10)) return 0;
      return 4;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         qa.delete(); qd.delete(); fq.delete();
         e_busy = 0; e_fast = 0; e_preq = 0; e_ereq = 0; e_paddr = '0; e_pdata = '0;
      end else begin
         e_preq = 0; e_ereq = 0;
         if (e_busy) begin
            if (op_done) e_busy = 0;
         end else if (wr_en && e_fast) begin
            if (fq.size() == 0) begin
               if (wr_data[7:0] == 8'hA0 || wr_data[7:0] == 8'h90) fq.push_back(wr_data[7:0]);
            end else begin
               if (fq[0] == 8'hA0) begin
                  e_preq = 1; e_busy = 1; e_paddr = wr_addr; e_pdata = wr_data;
               end else if (wr_data[7:0] == 8'h00) begin
                  e_fast = 0;
               end
               fq.delete();
            end
         end else if (wr_en) begin
            qa.push_back(wr_addr); qd.push_back(wr_data[7:0]);
            case (verdict())
               0: begin qa.delete(); qd.delete(); end
               2: begin e_preq = 1; e_busy = 1; e_paddr = wr_addr; e_pdata = wr_data;
                        qa.delete(); qd.delete(); end
               3: begin e_fast = 1; qa.delete(); qd.delete(); end
               4: begin e_ereq = 1; e_busy = 1; qa.delete(); qd.delete(); end
               default: ;
            endcase
         end
      end
   end

   task automatic cmp1(string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         cmp1("prog_req", 32'(prog_req), 32'(e_preq));
         cmp1("erase_req", 32'(erase_req), 32'(e_ereq));
         cmp1("busy", 32'(busy), 32'(e_busy));
         cmp1("fast_mode", 32'(fast_mode), 32'(e_fast));
         cmp1("read_mode", 32'(read_mode), 32'(!e_busy && !e_fast));
         cmp1("prog_addr", 32'(prog_addr), 32'(e_paddr));
         cmp1("prog_data", 32'(prog_data), 32'(e_pdata));
      end
   end

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic done_pulse();
      @(negedge clk);
      op_done = 1;
      @(negedge clk);
      op_done = 0;
   endtask

   task automatic unlock(logic [AW-1:0] hi);
      wr(hi | 20'h555, 16'h00AA);
      wr(hi | 20'h2AA, 16'h0055);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic summary();
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      n_bad++;
      $display("FAIL watchdog expired tag=%s actual=running expected=finished", tag);
      summary();
   end

   initial begin
      idle(3);
      @(negedge clk) rst_n = 1;
      // R1: explicit reset-state check
      tag = "R1";
      cmp1("reset busy", 32'(busy), 0);
      cmp1("reset fast", 32'(fast_mode), 0);
      cmp1("reset read_mode", 32'(read_mode), 1);
      cmp1("reset prog_addr", 32'(prog_addr), 0);
      idle(2);

      tag = "R12"; done_pulse(); idle(2);

      tag = "R2"; unlock(0); wr(20'h555, 16'h00A0); wr(20'h12345, 16'hBEEF); idle(2);
      tag = "R3"; unlock(0); wr(20'h555, 16'h0020); wr(20'h00100, 16'h00A0);
      wr(20'h00200, 16'h1111); idle(3);
      @(negedge clk); op_done = 1; wr_en = 1; wr_addr = 20'h555; wr_data = 16'h00AA;
      @(negedge clk); op_done = 0; wr_en = 0; idle(2);

      tag = "R10"; unlock(0); wr(20'h555, 16'h00F0); wr(20'h555, 16'h00A0); wr(20'h00333, 16'h2222);
      wr(20'h555, 16'h00AA); wr(20'h555, 16'h0055); wr(20'h2AA, 16'h0055);
      unlock(0); wr(20'h555, 16'h0080); wr(20'h555, 16'h00AA); wr(20'h2AA, 16'h00F0);
      wr(20'h555, 16'h0010); idle(2);
      unlock(0); wr(20'h555, 16'h0080); unlock(0); wr(20'h554, 16'h0010); idle(2);

      tag = "R11"; unlock(20'h80000); wr(20'hC0555, 16'h00A0); wr(20'hFFFFF, 16'hA5A5);
      idle(2); done_pulse(); unlock(20'h00800); wr(20'h00555, 16'h0020); idle(2);

      tag = "R5"; wr(20'h00000, 16'h00A0); wr(20'h0ABCD, 16'h5A5A); idle(2); done_pulse();
      wr(20'h77777, 16'hFFA0); wr(20'h00001, 16'h0001); idle(1); done_pulse();

      tag = "R6"; unlock(0); wr(20'h555, 16'h0080); wr(20'h555, 16'h0010); wr(20'h555, 16'h00F0);
      wr(20'h0, 16'h0000); idle(2);

      tag = "R7"; wr(20'h123, 16'h0090); wr(20'h456, 16'h0012); wr(20'h0, 16'h0011); idle(1);
      wr(20'hABCDE, 16'h0090); wr(20'h54321, 16'h0000); idle(2);

      tag = "R4"; unlock(0); wr(20'h555, 16'h0020); idle(2);
      wr(20'h0, 16'h0090); wr(20'h0, 16'hFF00); idle(2);

      tag = "R8"; unlock(0); wr(20'h555, 16'h0080); unlock(0); wr(20'h555, 16'h0010); idle(2);
      tag = "R9"; unlock(0); wr(20'h555, 16'h00A0); wr(20'h1, 16'h1); wr(20'h555, 16'h0020);
      idle(4); done_pulse(); idle(2);
      unlock(0); wr(20'h555, 16'h0020); idle(2);

      tag = "R12"; done_pulse(); wr(20'h0, 16'h0090); wr(20'h0, 16'h0000); done_pulse(); idle(3);
      summary();
   end

endmodule